// File: doc/BRIEF.md
# Write-Only I2C Register Target

This block is an I2C target that only accepts writes. It oversamples the bus lines with the system clock, detects START and STOP conditions, and checks the incoming address byte against a fixed 7-bit device address. The low two bits of that address come from a strap that says where an address pin is tied. After a matching address with the write direction, the first byte sets an internal register pointer. Every byte after that leaves the block as a one-cycle write strobe carrying the pointer and the byte. The pointer then moves on by one.

Each accepted byte is acknowledged by pulling SDA low through an open-drain enable during the ninth clock. A wrong address or a read request is left unacknowledged, and the block stays silent until the next START. A repeated START at any point begins a fresh address phase. Both bus lines pass through a two-flop synchroniser and a stability filter before any edge is used, so narrow spikes are rejected. The bus may run at up to 400 kHz, provided the system clock is many times faster than SCL.

Top module: `i2c_wr_target`

## Requirements
- R1: The address byte that is acknowledged is, MSB first, 1,1,0,1,1, then the two strap bits, then a direction bit of 0 (write).
- R2: The strap input `tie_sel` selects the two address bits as follows: code 0 (pin grounded) gives 00, code 1 (pin at supply) gives 11, code 2 (pin on the clock line) gives 01, and code 3 (pin on the data line) gives 10.
- R3: An address byte that does not match, or one whose direction bit is 1, gets no acknowledge. No later byte is acknowledged and no write strobe is produced until the next START.
- R4: After a matching address, the next byte is acknowledged and becomes the register pointer.
- R5: Each later byte, received MSB first with SDA sampled while SCL is high, is acknowledged. It also produces exactly one single-cycle `wr_valid` pulse with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R6: The pointer advances by one with each data byte, wrapping from 0xFF to 0x00, for as long as data bytes keep arriving.
- R7: A STOP (SDA rising while SCL is high) ends the transfer. Bytes clocked in afterwards without a new START are neither acknowledged nor written.
- R8: A repeated START (SDA falling while SCL is high) during a transfer restarts address reception. The following register byte replaces the pointer.
- R9: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored and does not shift a bit.
- R10: After reset, `sda_oe` and `wr_valid` are 0.
- R11: The acknowledge is released once SCL falls at the end of the ninth clock, so `sda_oe` is 0 during the following low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| tie_sel | input | 2 | Strap code giving the address pin's tie point |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
The write strobe for a byte and the pointer advance that follows it both happen on the same SCL falling edge that opens the acknowledge. The bench drives this hard with bursts whose start pointer sits near 0xFF, so the wrap and the strobe coincide. It judges each strobe's address against a sequence computed in the bench. The acknowledge release and the next byte's first bit also fall close together. The bench therefore changes SDA a fixed quarter period after each SCL fall and checks that every byte after an acknowledge arrives intact.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    localparam int BYTE_W = 8;
    localparam logic [4:0] DEV_PREFIX = 5'b11011;

    typedef enum logic [1:0] {
        TIE_GND = 2'd0,
        TIE_VCC = 2'd1,
        TIE_SCL = 2'd2,
        TIE_SDA = 2'd3
    } tie_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_DATA
    } state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic [1:0] strap_bits(tie_e t);
        case (t)
            TIE_GND: return 2'b00;
            TIE_VCC: return 2'b11;
            TIE_SCL: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] own_addr_byte(tie_e t);
        return {DEV_PREFIX, strap_bits(t), 1'b0};
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic             sync1, sync2;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1  <= 1'b1;
            sync2  <= 1'b1;
            filt_o <= 1'b1;
            cnt    <= '0;
        end else begin
            sync1 <= raw_i;
            sync2 <= sync1;
            if (sync2 == filt_o) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
                filt_o <= sync2;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (filt_o != $past(filt_o)) |-> ($past(sync2) == filt_o && $past(cnt) == CNT_W'(FILT_LEN - 1))); // R9

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_wr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.scl_rise = scl_f & ~scl_q;
        evt.scl_fall = ~scl_f & scl_q;
        evt.start    = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop     = scl_f & scl_q & ~sda_q & sda_f;
        evt.sda      = sda_f;
    end

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import i2c_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] own_addr,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int BC_W = $clog2(BYTE_W + 1);

    state_e            state;
    logic [BC_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              in_ack;

    wire byte_done = (bit_cnt == BC_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            in_ack   <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (evt.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (evt.scl_rise && !in_ack && !byte_done) begin
                    shreg   <= {shreg[BYTE_W-2:0], evt.sda};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (evt.scl_fall) begin
                    if (in_ack) begin
                        in_ack <= 1'b0;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        case (state)
                            ST_ADDR: begin
                                if (shreg == own_addr) begin
                                    in_ack <= 1'b1;
                                    state  <= ST_REG;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end
                            ST_REG: begin
                                ptr    <= shreg;
                                in_ack <= 1'b1;
                                state  <= ST_DATA;
                            end
                            default: begin
                                wr_valid <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= shreg;
                                ptr      <= ptr + 1'b1;
                                in_ack   <= 1'b1;
                            end
                        endcase
                    end
                end
            end
        end
    end

    assign sda_oe = in_ack;

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (ptr == wr_addr + 1'b1)); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_DATA && !wr_valid) |-> $stable(ptr)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!sda_oe && !wr_valid)); // R3
    AST_START_REARM: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR && bit_cnt == '0)); // R8
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe)); // R7
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && evt.scl_fall && !evt.start && !evt.stop) |=> !sda_oe); // R11

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2c_wr_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  tie_sel,
    output logic        sda_oe,
    output logic        wr_valid,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    bus_evt_t           evt;
    logic [BYTE_W-1:0]  own_addr;

    assign raw_lines = {sda_i, scl_i};
    assign own_addr  = own_addr_byte(tie_e'(tie_sel));

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    i2c_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_lines[0]),
        .sda_f (filt_lines[1]),
        .evt   (evt)
    );

    i2c_wr_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .own_addr (own_addr),
        .sda_oe   (sda_oe),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !wr_valid)); // R10

endmodule

// File: tb/test_i2c_wr_target.sv
module test_i2c_wr_target;
    localparam int CLK_PERIOD = 10;
    localparam int QP = 12;
    localparam int HP = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] tie = 2'd0;
    logic       sda_bus;
    logic       sda_oe, wr_valid;
    logic [7:0] wr_addr, wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] cap_a [0:1023];
    logic [7:0] cap_d [0:1023];
    int         cap_n = 0;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_wr_target #(.FILT_LEN(3)) i_i2c_wr_target (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .tie_sel  (tie),
        .sda_oe   (sda_oe),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst && wr_valid && cap_n < 1024) begin
            cap_a[cap_n] <= wr_addr;
            cap_d[cap_n] <= wr_data;
            cap_n        <= cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_dev(input logic [1:0] t);
        logic [1:0] s;
        case (t)
            2'd0: s = 2'b00;
            2'd1: s = 2'b11;
            2'd2: s = 2'b01;
            default: s = 2'b10;
        endcase
        return {5'b11011, s, 1'b0};
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(QP);
        m_scl = 1'b1; wt(HP);
        m_sda = 1'b0; wt(HP);
        m_scl = 1'b0; wt(QP);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(QP);
        m_scl = 1'b1; wt(HP);
        m_sda = 1'b1; wt(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack, output bit rel);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(QP);
            m_scl = 1'b1; wt(HP);
            m_scl = 1'b0; wt(QP);
            if (glitch && i == 4) begin
                m_scl = 1'b1; wt(1);
                m_scl = 1'b0; wt(QP);
            end
        end
        m_sda = 1'b1; wt(QP);
        m_scl = 1'b1; wt(HP/2);
        ack = (sda_bus == 1'b0);
        wt(HP/2);
        m_scl = 1'b0; wt(QP);
        rel = (sda_oe == 1'b0);
    endtask

    // Full write: START, device byte, register byte, n data bytes, STOP.
    task automatic xfer(input logic [7:0] dev, input logic [7:0] rg, input int n,
                        input bit exp_ack, input bit glitch);
        logic [7:0] dat [0:15];
        bit ack, rel;
        int base;
        base = cap_n;
        bus_start();
        send_byte(dev, 1'b0, ack, rel);
        chk(ack == exp_ack, exp_ack ? "R1 R2 address ack" : "R3 address nack", ack, exp_ack);
        send_byte(rg, 1'b0, ack, rel);
        chk(ack == exp_ack, "R4 register byte ack", ack, exp_ack);
        for (int k = 0; k < n; k++) begin
            dat[k] = 8'($urandom);
            send_byte(dat[k], glitch && k == 0, ack, rel);
            chk(ack == exp_ack, "R5 data byte ack", ack, exp_ack);
            chk(rel, "R11 ack released after ninth clock", rel, 1);
        end
        bus_stop();
        wt(4);
        chk(cap_n - base == (exp_ack ? n : 0), exp_ack ? "R5 strobe count" : "R3 no strobes", cap_n - base, exp_ack ? n : 0);
        if (exp_ack && cap_n - base == n) begin
            for (int k = 0; k < n; k++) begin
                chk(cap_a[base+k] == 8'(rg + k), "R6 pointer sequence", cap_a[base+k], 8'(rg + k));
                chk(cap_d[base+k] == dat[k], glitch ? "R9 glitch rejected, data intact" : "R5 data byte", cap_d[base+k], dat[k]);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack, rel;
        int base;
        void'($urandom(32'h5EED_1234));
        wt(5);
        chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
        chk(wr_valid == 1'b0, "R10 reset wr_valid", wr_valid, 0);
        rst = 1'b0;
        wt(10);

        // Every strap code, matching address
        for (int t = 0; t < 4; t++) begin
            tie = 2'(t);
            wt(4);
            xfer(exp_dev(2'(t)), 8'(8'h20 + t), 2, 1'b1, 1'b0);
        end

        // Wrong strap bits: address of code 1 while strapped to code 0 (R3)
        tie = 2'd0; wt(4);
        xfer(exp_dev(2'd1), 8'h05, 2, 1'b0, 1'b0);
        // Wrong prefix (R3)
        xfer(8'b1101_0000 ^ 8'h80, 8'h05, 1, 1'b0, 1'b0);
        // Read request (R3)
        xfer(exp_dev(2'd0) | 8'h01, 8'h05, 2, 1'b0, 1'b0);

        // Pointer wrap (R6)
        xfer(exp_dev(2'd0), 8'hFE, 4, 1'b1, 1'b0);

        // SCL glitch inside first data byte (R9)
        xfer(exp_dev(2'd0), 8'h33, 2, 1'b1, 1'b1);

        // Bytes after STOP without a new START (R7)
        base = cap_n;
        m_sda = 1'b1; wt(QP);
        m_scl = 1'b0; wt(QP);
        send_byte(exp_dev(2'd0), 1'b0, ack, rel);
        chk(ack == 1'b0, "R7 no ack after STOP", ack, 0);
        send_byte(8'h44, 1'b0, ack, rel);
        chk(ack == 1'b0, "R7 no ack after STOP", ack, 0);
        m_scl = 1'b1; wt(HP);
        wt(4);
        chk(cap_n == base, "R7 no strobe after STOP", cap_n - base, 0);

        // Repeated START mid-transfer (R8)
        base = cap_n;
        bus_start();
        send_byte(exp_dev(2'd0), 1'b0, ack, rel);
        send_byte(8'h10, 1'b0, ack, rel);
        send_byte(8'hA5, 1'b0, ack, rel);
        bus_start();
        send_byte(exp_dev(2'd0), 1'b0, ack, rel);
        chk(ack == 1'b1, "R8 address ack after repeated START", ack, 1);
        send_byte(8'h40, 1'b0, ack, rel);
        send_byte(8'h5A, 1'b0, ack, rel);
        bus_stop();
        wt(4);
        chk(cap_n - base == 2, "R8 strobe count", cap_n - base, 2);
        chk(cap_a[base+1] == 8'h40, "R8 pointer reloaded", cap_a[base+1], 8'h40);
        chk(cap_d[base+1] == 8'h5A, "R8 data after restart", cap_d[base+1], 8'h5A);

        // Repeated START in the middle of a data byte (R8)
        base = cap_n;
        bus_start();
        send_byte(exp_dev(2'd0), 1'b0, ack, rel);
        send_byte(8'h60, 1'b0, ack, rel);
        for (int i = 0; i < 3; i++) begin
            m_sda = 1'b0; wt(QP); m_scl = 1'b1; wt(HP); m_scl = 1'b0; wt(QP);
        end
        bus_start();
        send_byte(exp_dev(2'd0), 1'b0, ack, rel);
        chk(ack == 1'b1, "R8 restart inside a byte", ack, 1);
        send_byte(8'h70, 1'b0, ack, rel);
        send_byte(8'h11, 1'b0, ack, rel);
        bus_stop();
        wt(4);
        chk(cap_n - base == 1 && cap_a[base] == 8'h70, "R8 partial byte dropped", cap_n - base, 1);

        // Random transactions
        for (int r = 0; r < 20; r++) begin
            logic [1:0] t;
            bit good;
            t = 2'($urandom);
            tie = t; wt(4);
            good = ($urandom % 4) != 0;
            xfer(good ? exp_dev(t) : (exp_dev(t) ^ 8'(1 << ($urandom % 8))),
                 8'($urandom), 1 + int'($urandom % 5), good, 1'b0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule